// File: doc/BRIEF.md
# Serial Video Lock Controller

This block decides when a serial digital video receiver is locked to its input. It watches an active-low carrier-present flag, the reclocker's PLL lock flag and single-cycle pulses from two sync-word detectors (SMPTE TRS and DVB-ASI). Two configuration pins select the expected format: SMPTE, DVB-ASI or raw data-through. From these it drives a lock flag, a data-output mute, a request to park the VCO at mid-range, a PLL-only mode flag, a pass-through enable and an active-low data-error flag.

When the carrier is valid, the controller hunts for sync. It makes a fixed number of timed attempts, and each attempt is a window of clock cycles. If every attempt fails, it drops into an unassisted PLL-only mode. In that mode, PLL lock alone enables pass-through, and lock is reported only for data-through format. A separate timeout returns the controller to hunting if the PLL never locks. The analog reclocker, the word detectors and the deserializer sit outside and are modelled by the bench.

Top module: `svl_lock_ctrl`

## Requirements
- R1: In reset and whenever the controller sits in its no-signal state, `locked`=0, `vco_center`=1, `pll_only`=0, `pass_thru`=0 and `data_err_n`=1. `mute`=1 unless DVB-ASI format is selected.
- R2: The format is decoded from {`cfg_smpte_byp`,`cfg_asi`}: 2'b10 is SMPTE, 2'b01 is DVB-ASI, 2'b00 is data-through and 2'b11 is invalid. With DVB-ASI selected, `mute` stays 0 in the no-signal state.
- R3: `carrier_n`=1 sampled in any state puts the controller in the no-signal state one cycle later and restarts the attempt count.
- R4: When the carrier is present, the controller hunts. A matching sync pulse (`trs_hit` for SMPTE, `asi_hit` for DVB-ASI) sampled with `pll_lock`=1 raises `locked` one cycle later.
- R5: A sync pulse that does not match the selected format, and any pulse under data-through or invalid format, has no effect.
- R6: Each hunt attempt lasts HUNT_CYC cycles. `pll_only` rises exactly HUNT_TRIES*HUNT_CYC cycles after hunting begins if no attempt succeeds.
- R7: In PLL-only mode, `pll_lock`=1 sets `pass_thru`=1 one cycle later. `locked` is then 1 only for data-through format.
- R8: `data_err_n` is 0 while passing through with a format other than data-through.
- R9: Loss of `pll_lock` while locked or passing through returns the controller to hunting with the attempt count restarted.
- R10: If PLL-only mode sees no `pll_lock` for PLL_TMO_CYC cycles, the controller returns to hunting. The default is 2,500,000 cycles, which is 10 ms at 250 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| carrier_n | input | 1 | Low when a valid serial input is present |
| pll_lock | input | 1 | Reclocker PLL lock flag |
| trs_hit | input | 1 | Pulse: SMPTE TRS sync word seen |
| asi_hit | input | 1 | Pulse: DVB-ASI sync word seen |
| cfg_smpte_byp | input | 1 | Format select, high for SMPTE |
| cfg_asi | input | 1 | Format select, high for DVB-ASI |
| locked | output | 1 | Receiver lock indication |
| mute | output | 1 | Mute the parallel data outputs |
| vco_center | output | 1 | Hold the VCO at the centre of its pull range |
| pll_only | output | 1 | Unassisted PLL-only lock mode active |
| pass_thru | output | 1 | Data passed directly to outputs |
| data_err_n | output | 1 | Low on format mismatch during pass-through |

## Verification
Every state output is decoded from the registered state. A `carrier_n`, `pll_lock` or sync pulse sampled at one rising edge therefore shows on the outputs just after that edge, one cycle later. `mute`, `locked` and `data_err_n` follow the format pins combinationally within the current state. The bench drives inputs on the falling edge, waits one rising edge, and samples on the next falling edge. It counts edges from hunt entry, so the window and timeout boundaries are checked one cycle before the transition and again at the transition itself.

// File: rtl/svl_lock_pkg.sv
package svl_lock_pkg;

  typedef enum logic [2:0] {
    ST_NOSIG     = 3'd0,
    ST_HUNT      = 3'd1,
    ST_SYNC_LOCK = 3'd2,
    ST_PLL_HUNT  = 3'd3,
    ST_PLL_PASS  = 3'd4
  } lk_state_t;

  // encoding is {smpte_byp, asi}
  typedef enum logic [1:0] {
    FMT_THRU  = 2'b00,
    FMT_ASI   = 2'b01,
    FMT_SMPTE = 2'b10,
    FMT_BAD   = 2'b11
  } fmt_t;

endpackage

// File: rtl/svl_fmt_decode.sv
module svl_fmt_decode
  import svl_lock_pkg::*;
(
  input  logic cfg_smpte_byp,
  input  logic cfg_asi,
  input  logic trs_hit,
  input  logic asi_hit,
  output logic sync_ok,
  output logic is_asi,
  output logic is_thru
);

  fmt_t fmt;

  always_comb begin
    fmt     = fmt_t'({cfg_smpte_byp, cfg_asi});
    is_asi  = (fmt == FMT_ASI);
    is_thru = (fmt == FMT_THRU);
    unique case (fmt)
      FMT_SMPTE: sync_ok = trs_hit;
      FMT_ASI:   sync_ok = asi_hit;
      default:   sync_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/svl_win_timer.sv
module svl_win_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] cnt
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr || (cnt_q != CNT_MAX);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/svl_try_ctr.sv
module svl_try_ctr #(
  parameter int TRIES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);

  localparam int TW = (TRIES > 1) ? $clog2(TRIES) : 1;
  localparam logic [TW-1:0] LAST_V = TW'(TRIES - 1);

  logic [TW-1:0] try_q;
  logic [TW-1:0] try_d;
  logic          try_en;

  always_comb begin
    try_en = clr || (inc && (try_q != LAST_V));
    try_d  = clr ? '0 : try_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      try_q <= '0;
    end else if (try_en) begin
      try_q <= try_d;
    end
  end

  assign last = (try_q == LAST_V);

endmodule

// File: rtl/svl_lock_fsm.sv
module svl_lock_fsm
  import svl_lock_pkg::*;
#(
  parameter int HUNT_CYC = 4096,
  parameter int PLL_TMO  = 2500000,
  parameter int CW       = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          carrier_n,
  input  logic          pll_lock,
  input  logic          sync_ok,
  input  logic          is_asi,
  input  logic          is_thru,
  input  logic [CW-1:0] cnt,
  input  logic          last_try,
  output logic          tmr_clr,
  output logic          try_clr,
  output logic          try_inc,
  output logic          locked,
  output logic          mute,
  output logic          vco_center,
  output logic          pll_only,
  output logic          pass_thru,
  output logic          data_err_n
);

  localparam logic [CW-1:0] HUNT_END = CW'(HUNT_CYC - 1);
  localparam logic [CW-1:0] PLL_END  = CW'(PLL_TMO - 1);

  lk_state_t st_q;
  lk_state_t st_d;
  logic      win_end;

  // next-state
  always_comb begin
    st_d    = st_q;
    try_clr = 1'b0;
    try_inc = 1'b0;
    win_end = 1'b0;
    if (carrier_n) begin
      st_d    = ST_NOSIG;
      try_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_NOSIG: begin
          st_d    = ST_HUNT;
          try_clr = 1'b1;
        end
        ST_HUNT: begin
          if (pll_lock && sync_ok) begin
            st_d = ST_SYNC_LOCK;
          end else if (cnt == HUNT_END) begin
            if (last_try) begin
              st_d = ST_PLL_HUNT;
            end else begin
              try_inc = 1'b1;
              win_end = 1'b1;
            end
          end
        end
        ST_SYNC_LOCK: begin
          if (!pll_lock) begin
            st_d    = ST_HUNT;
            try_clr = 1'b1;
          end
        end
        ST_PLL_HUNT: begin
          if (pll_lock) begin
            st_d = ST_PLL_PASS;
          end else if (cnt == PLL_END) begin
            st_d    = ST_HUNT;
            try_clr = 1'b1;
          end
        end
        ST_PLL_PASS: begin
          if (!pll_lock) begin
            st_d    = ST_HUNT;
            try_clr = 1'b1;
          end
        end
        default: begin
          st_d    = ST_NOSIG;
          try_clr = 1'b1;
        end
      endcase
    end
    tmr_clr = win_end || (st_d != st_q);
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_NOSIG;
    end else begin
      st_q <= st_d;
    end
  end

  // output decode
  always_comb begin
    vco_center = (st_q == ST_NOSIG);
    mute       = (st_q == ST_NOSIG) && !is_asi;
    pll_only   = (st_q == ST_PLL_HUNT) || (st_q == ST_PLL_PASS);
    pass_thru  = (st_q == ST_PLL_PASS);
    locked     = (st_q == ST_SYNC_LOCK) || ((st_q == ST_PLL_PASS) && is_thru);
    data_err_n = !((st_q == ST_PLL_PASS) && !is_thru);
  end

endmodule

// File: rtl/svl_lock_ctrl.sv
module svl_lock_ctrl #(
  parameter int HUNT_CYC     = 4096,
  parameter int HUNT_TRIES   = 4,
  parameter int PLL_TMO_CYC  = 2500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic carrier_n,
  input  logic pll_lock,
  input  logic trs_hit,
  input  logic asi_hit,
  input  logic cfg_smpte_byp,
  input  logic cfg_asi,
  output logic locked,
  output logic mute,
  output logic vco_center,
  output logic pll_only,
  output logic pass_thru,
  output logic data_err_n
);

  localparam int MAX_WIN = (PLL_TMO_CYC > HUNT_CYC) ? PLL_TMO_CYC : HUNT_CYC;
  localparam int CW      = $clog2(MAX_WIN + 1);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  logic          sync_ok;
  logic          is_asi;
  logic          is_thru;
  logic          tmr_clr;
  logic          try_clr;
  logic          try_inc;
  logic          last_try;
  logic [CW-1:0] cnt;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync_q[1];

  svl_fmt_decode u_fmt (
    .cfg_smpte_byp (cfg_smpte_byp),
    .cfg_asi       (cfg_asi),
    .trs_hit       (trs_hit),
    .asi_hit       (asi_hit),
    .sync_ok       (sync_ok),
    .is_asi        (is_asi),
    .is_thru       (is_thru)
  );

  svl_win_timer #(.CW(CW)) u_tmr (
    .clk   (clk),
    .rst_n (core_rst_n),
    .clr   (tmr_clr),
    .cnt   (cnt)
  );

  svl_try_ctr #(.TRIES(HUNT_TRIES)) u_try (
    .clk   (clk),
    .rst_n (core_rst_n),
    .clr   (try_clr),
    .inc   (try_inc),
    .last  (last_try)
  );

  svl_lock_fsm #(
    .HUNT_CYC (HUNT_CYC),
    .PLL_TMO  (PLL_TMO_CYC),
    .CW       (CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .carrier_n  (carrier_n),
    .pll_lock   (pll_lock),
    .sync_ok    (sync_ok),
    .is_asi     (is_asi),
    .is_thru    (is_thru),
    .cnt        (cnt),
    .last_try   (last_try),
    .tmr_clr    (tmr_clr),
    .try_clr    (try_clr),
    .try_inc    (try_inc),
    .locked     (locked),
    .mute       (mute),
    .vco_center (vco_center),
    .pll_only   (pll_only),
    .pass_thru  (pass_thru),
    .data_err_n (data_err_n)
  );

endmodule

// File: rtl/svl_lock_ctrl_chk.sv
module svl_lock_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic carrier_n,
  input logic pll_lock,
  input logic cfg_smpte_byp,
  input logic cfg_asi,
  input logic locked,
  input logic mute,
  input logic vco_center,
  input logic pll_only,
  input logic pass_thru,
  input logic data_err_n
);

  // R3 and R1: an invalid carrier forces the parked, unlocked state next cycle
  p_nosig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_n |=> (vco_center && !locked && !pll_only && !pass_thru));

  // R2: DVB-ASI format never mutes while parked
  p_asi_nomute_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_center && cfg_asi && !cfg_smpte_byp) |-> !mute);

  // R4: sync-assisted lock only rises with PLL lock present the cycle before
  p_lock_needs_pll_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(locked) && !pll_only) |-> $past(pll_lock));

  // R9: losing PLL lock while locked drops lock next cycle
  p_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !pll_lock && !carrier_n) |=> (!locked && !pll_only));

  // R7: lock in pass-through only with data-through format
  p_pass_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_thru && locked) |-> (!cfg_smpte_byp && !cfg_asi));

  // R8: data error only flagged during pass-through, never with lock
  p_derr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_err_n |-> (pass_thru && pll_only && !locked));

endmodule

bind svl_lock_ctrl svl_lock_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .carrier_n     (carrier_n),
  .pll_lock      (pll_lock),
  .cfg_smpte_byp (cfg_smpte_byp),
  .cfg_asi       (cfg_asi),
  .locked        (locked),
  .mute          (mute),
  .vco_center    (vco_center),
  .pll_only      (pll_only),
  .pass_thru     (pass_thru),
  .data_err_n    (data_err_n)
);

// File: tb/svl_lock_ctrl_tb.sv
`timescale 1ns/1ps
module svl_lock_ctrl_tb;

  localparam int HC  = 8;
  localparam int NT  = 4;
  localparam int TMO = 50;
  localparam int NV  = 14;

  // stim {carrier_n, pll_lock, trs_hit, asi_hit, cfg_smpte_byp, cfg_asi}
  // exp  {locked, mute, vco_center, pll_only, pass_thru, data_err_n}
  localparam logic [11:0] VEC [NV] = '{
    12'b100010_011001,  // R1 parked, SMPTE
    12'b000010_000001,  // R4 hunt
    12'b011010_100001,  // R4 TRS with PLL -> lock
    12'b010010_100001,  // R4 hold lock
    12'b000010_000001,  // R9 PLL lost -> hunt
    12'b010110_000001,  // R5 ASI pulse ignored under SMPTE
    12'b011010_100001,  // R4 relock
    12'b110010_011001,  // R3 carrier gone
    12'b100001_001001,  // R2 ASI parked, no mute
    12'b000001_000001,  // R2 hunt under ASI
    12'b011001_000001,  // R5 TRS ignored under ASI
    12'b010101_100001,  // R4 ASI lock
    12'b100011_011001,  // R2 invalid format parked, muted
    12'b011111_000001   // R5 invalid format ignores both pulses
  };

  logic clk;
  logic rst_n;
  logic carrier_n, pll_lock, trs_hit, asi_hit, cfg_smpte_byp, cfg_asi;
  logic locked, mute, vco_center, pll_only, pass_thru, data_err_n;
  int   n_run;
  int   n_fail;
  logic done;

  svl_lock_ctrl #(
    .HUNT_CYC    (HC),
    .HUNT_TRIES  (NT),
    .PLL_TMO_CYC (TMO)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .carrier_n     (carrier_n),
    .pll_lock      (pll_lock),
    .trs_hit       (trs_hit),
    .asi_hit       (asi_hit),
    .cfg_smpte_byp (cfg_smpte_byp),
    .cfg_asi       (cfg_asi),
    .locked        (locked),
    .mute          (mute),
    .vco_center    (vco_center),
    .pll_only      (pll_only),
    .pass_thru     (pass_thru),
    .data_err_n    (data_err_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [5:0] outs();
    return {locked, mute, vco_center, pll_only, pass_thru, data_err_n};
  endfunction

  task automatic chk(input string tag, input logic [5:0] exp);
    n_run++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s act=%b exp=%b", tag, outs(), exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic drive(input logic [5:0] s);
    {carrier_n, pll_lock, trs_hit, asi_hit, cfg_smpte_byp, cfg_asi} = s;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    n_run  = 0;
    n_fail = 0;
    rst_n  = 1'b0;
    drive(6'b100010);
    steps(3);
    chk("R1 reset state", 6'b011001);
    rst_n = 1'b1;
    steps(3);
    chk("R1 after release", 6'b011001);

    // table walk: each vector applied, one edge, sampled
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][11:6]);
      step();
      chk($sformatf("vector %0d R1 R2 R3 R4 R5", v), VEC[v][5:0]);
    end

    // R6: hunt exhaustion boundary, data-through format
    drive(6'b100000); step();
    drive(6'b000000); step();          // hunt entered
    steps(NT*HC - 1);
    chk("R6 one cycle before PLL-only", 6'b000001);
    step();
    chk("R6 PLL-only entered", 6'b000101);

    // R7: PLL lock in PLL-only mode, data-through reports lock
    pll_lock = 1'b1; step();
    chk("R7 pass-through locked", 6'b100111);

    // R9: lock lost -> hunt, attempt count restarted
    pll_lock = 1'b0; step();
    chk("R9 back to hunt", 6'b000001);
    steps(NT*HC - 1);
    chk("R9 full hunt again before PLL-only", 6'b000001);
    step();
    chk("R9 PLL-only after full hunt", 6'b000101);

    // R10: PLL-only timeout
    steps(TMO - 1);
    chk("R10 before timeout", 6'b000101);
    step();
    chk("R10 timeout back to hunt", 6'b000001);

    // R8 and R7 with SMPTE format through PLL-only path
    cfg_smpte_byp = 1'b1;
    steps(NT*HC);
    chk("R6 PLL-only under SMPTE", 6'b000101);
    pll_lock = 1'b1; step();
    chk("R8 pass-through data error, no lock", 6'b000110);
    cfg_smpte_byp = 1'b0;
    #1;
    chk("R7 data-through format enables lock", 6'b100111);
    cfg_smpte_byp = 1'b1;
    pll_lock = 1'b0; step();

    // R3: carrier loss mid-hunt restarts the attempts
    drive(6'b100010); step();
    drive(6'b000010); step();
    steps(20);
    carrier_n = 1'b1; step();
    chk("R3 carrier loss mid-hunt", 6'b011001);
    carrier_n = 1'b0; step();
    steps(NT*HC - 1);
    chk("R3 attempts restarted", 6'b000001);
    step();
    chk("R3 PLL-only after full count", 6'b000101);

    // R1: asynchronous reset mid-run
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    chk("R1 async reset", 6'b011001);
    steps(2);
    rst_n = 1'b1;
    steps(3);

    done = 1'b1;
    finish_run();
  end

endmodule